// File: doc/BRIEF.md
# Half-Bridge Switch Sequencer with Dead Time

This block turns the programmed state of a set of half-bridges into separate on-commands for each bridge's high-side and low-side switch. Each bridge has two programmed bits. The first selects whether the bridge drives at all. The second picks the side that conducts: the sinking low side or the sourcing high side. Fault logic elsewhere can latch any single bridge off. A global supply-lockout flag turns every switch off but leaves the programmed state in place.

Whenever a bridge changes which side conducts, the block passes through a break-before-make interval. The interval is counted in system-clock cycles and set by a parameter. Each bridge has its own timer, so one bridge switching never delays another. The block also returns, for each bridge, the enable and side-select values that it is actually acting on. A serial front end can read these back for reporting.

Every input is a plain control level sampled on the system clock. The switch outputs are registered. There is no streaming data path, so there is no valid/ready handshake.

Top module: `hb_gate_ctrl`

## Requirements
- R1: When a bridge's enable bit is 0 and it has been stable for at least one clock edge, both of that bridge's switch outputs are 0, whatever its side-select bit is.
- R2: In steady state, with enable 1 and no fault or lockout, side-select 0 gives low side on and high side off, and side-select 1 gives high side on and low side off.
- R3: A bridge's high-side and low-side outputs are never 1 in the same cycle.
- R4: When the requested side flips from one side to the other, the side that was on turns off at the first clock edge. Both outputs then stay 0 for exactly DEAD_CYCLES clock cycles, and the new side turns on at edge DEAD_CYCLES+1.
- R5: If the request passes through high impedance, a side that is the opposite of the one last on still turns on only DEAD_CYCLES cycles after that side went off. If the request returns to the same side that was last on, that side turns on again at the next edge.
- R6: While supply_lock is 1, all switch outputs are 0 from the next clock edge on. The echo outputs keep the programmed values. After supply_lock returns to 0, the programmed outputs come back on their own.
- R7: A bridge whose fault_off bit is 1 has both switch outputs at 0 from the next edge on. Its en_echo and cfg_echo bits read 0 in the same cycle.
- R8: While rst_n is low, every switch output is 0 and every dead-time timer is cleared.
- R9: en_echo equals bridge_en AND NOT fault_off, and cfg_echo equals bridge_cfg AND NOT fault_off. Both are combinational and do not depend on supply_lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bridge_en | input | NUM | Per-bridge drive enable (0 = high impedance) |
| bridge_cfg | input | NUM | Per-bridge side select (0 = low side, 1 = high side) |
| fault_off | input | NUM | Per-bridge latched-off mask from fault logic |
| supply_lock | input | 1 | Global supply lockout, all switches off |
| hs_on | output | NUM | High-side switch on-commands |
| ls_on | output | NUM | Low-side switch on-commands |
| en_echo | output | NUM | Effective enable per bridge, for status reporting |
| cfg_echo | output | NUM | Effective side select per bridge, for status reporting |

## Verification
The most likely internal faults are a wrong dead-time counter value and a stale record of which side was last on. Both show at the ports as a change in the cycle on which the new side rises after a flip. That shift appears within DEAD_CYCLES+1 edges of the request, so the bench counts edges exactly in both directions and through a high-impedance detour. A wrong decode or masking term shows as a wrong steady output within DEAD_CYCLES+2 edges. A sweep over enable, side-select, fault and lockout patterns for all bridges catches it.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;
  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_LOW  = 2'd1,
    SIDE_HIGH = 2'd2
  } side_e;
endpackage

// File: rtl/hb_side_decode.sv
module hb_side_decode
  import hb_gate_pkg::*;
(
  input  logic  en,
  input  logic  cfg,
  input  logic  kill,
  output side_e want
);
  always_comb begin
    if (kill || !en) want = SIDE_NONE;
    else if (cfg)    want = SIDE_HIGH;
    else             want = SIDE_LOW;
  end
endmodule

// File: rtl/hb_dead_timer.sv
module hb_dead_timer
  import hb_gate_pkg::*;
#(
  parameter int DEAD_CYCLES = 150
) (
  input  logic  clk,
  input  logic  rst_n,
  input  side_e want,
  output logic  hs_q,
  output logic  ls_q
);
  localparam int CW = (DEAD_CYCLES < 2) ? 1 : $clog2(DEAD_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(DEAD_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  side_e         last_q, last_d, cur;
  logic          hs_d, ls_d;

  always_comb begin
    if (hs_q)      cur = SIDE_HIGH;
    else if (ls_q) cur = SIDE_LOW;
    else           cur = SIDE_NONE;
  end

  always_comb begin
    hs_d   = hs_q;
    ls_d   = ls_q;
    last_d = last_q;
    cnt_d  = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    if (cur != SIDE_NONE && want != cur) begin
      // break first; the timer starts at the turn-off edge
      hs_d   = 1'b0;
      ls_d   = 1'b0;
      last_d = cur;
      cnt_d  = LOAD;
    end else if (cur == SIDE_NONE && want != SIDE_NONE &&
                 (cnt_q == '0 || want == last_q)) begin
      hs_d = (want == SIDE_HIGH);
      ls_d = (want == SIDE_LOW);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q   <= 1'b0;
      ls_q   <= 1'b0;
      cnt_q  <= '0;
      last_q <= SIDE_NONE;
    end else begin
      hs_q   <= hs_d;
      ls_q   <= ls_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_gate_pkg::*;
#(
  parameter int NUM         = 6,
  parameter int DEAD_CYCLES = 150
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] bridge_en,
  input  logic [NUM-1:0] bridge_cfg,
  input  logic [NUM-1:0] fault_off,
  input  logic           supply_lock,
  output logic [NUM-1:0] hs_on,
  output logic [NUM-1:0] ls_on,
  output logic [NUM-1:0] en_echo,
  output logic [NUM-1:0] cfg_echo
);
  assign en_echo  = bridge_en  & ~fault_off;
  assign cfg_echo = bridge_cfg & ~fault_off;

  for (genvar g = 0; g < NUM; g++) begin : g_br
    side_e want;
    hb_side_decode u_dec (
      .en   (bridge_en[g]),
      .cfg  (bridge_cfg[g]),
      .kill (fault_off[g] | supply_lock),
      .want (want)
    );
    hb_dead_timer #(.DEAD_CYCLES(DEAD_CYCLES)) u_dt (
      .clk  (clk),
      .rst_n(rst_n),
      .want (want),
      .hs_q (hs_on[g]),
      .ls_q (ls_on[g])
    );
  end
endmodule

// File: rtl/hb_gate_chk.sv
module hb_gate_chk #(
  parameter int NUM         = 6,
  parameter int DEAD_CYCLES = 150
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NUM-1:0] bridge_en,
  input logic [NUM-1:0] fault_off,
  input logic           supply_lock,
  input logic [NUM-1:0] hs_on,
  input logic [NUM-1:0] ls_on
);
  localparam int CW = $clog2(DEAD_CYCLES + 2);
  localparam logic [CW-1:0] SAT = CW'(DEAD_CYCLES);

  for (genvar g = 0; g < NUM; g++) begin : g_c
    logic [CW-1:0] off_run;
    logic          was_hi, was_lo;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        off_run <= '0;
        was_hi  <= 1'b0;
        was_lo  <= 1'b0;
      end else begin
        if (hs_on[g] || ls_on[g]) off_run <= '0;
        else if (off_run != SAT)  off_run <= off_run + 1'b1;
        if (hs_on[g])      begin was_hi <= 1'b1; was_lo <= 1'b0; end
        else if (ls_on[g]) begin was_hi <= 1'b0; was_lo <= 1'b1; end
      end
    end

    // R3
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_on[g] && ls_on[g]));
    // R4
    low_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ls_on[g]) && was_hi) |-> (off_run >= SAT));
    // R4
    high_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hs_on[g]) && was_lo) |-> (off_run >= SAT));
    // R1
    idle_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bridge_en[g] |=> (!hs_on[g] && !ls_on[g]));
    // R7
    fault_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_off[g] |=> (!hs_on[g] && !ls_on[g]));
  end

  // R6
  lockout_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_lock |=> (hs_on == '0 && ls_on == '0));
endmodule

bind hb_gate_ctrl hb_gate_chk #(.NUM(NUM), .DEAD_CYCLES(DEAD_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bridge_en(bridge_en), .fault_off(fault_off),
  .supply_lock(supply_lock), .hs_on(hs_on), .ls_on(ls_on)
);

// File: tb/hb_gate_ctrl_test.sv
`timescale 1ns/1ps
module hb_gate_ctrl_test;
  localparam int N = 6;
  localparam int D = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] en = '0, cfg = '0, flt = '0;
  logic lock = 1'b0;
  logic [N-1:0] hs, ls, ee, ce;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  hb_gate_ctrl #(.NUM(N), .DEAD_CYCLES(D)) uut (
    .clk(clk), .rst_n(rst_n), .bridge_en(en), .bridge_cfg(cfg),
    .fault_off(flt), .supply_lock(lock), .hs_on(hs), .ls_on(ls),
    .en_echo(ee), .cfg_echo(ce)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic steady(input string req);
    logic [N-1:0] eh, el;
    eh = en & cfg & ~flt & {N{~lock}};
    el = en & ~cfg & ~flt & {N{~lock}};
    check(hs == eh, req, 32'(hs), 32'(eh));
    check(ls == el, req, 32'(ls), 32'(el));
    check(ee == (en & ~flt), "R9 en_echo", 32'(ee), 32'(en & ~flt));
    check(ce == (cfg & ~flt), "R9 cfg_echo", 32'(ce), 32'(cfg & ~flt));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    en = '1; cfg = 6'b101010;
    step(3);
    // R8 reset holds outputs low
    check(hs == '0 && ls == '0, "R8", 32'({hs, ls}), 32'h0);
    en = '0; cfg = '0;
    rst_n = 1'b1;
    step(2);

    // R4 low -> high on bridge 0
    en = 6'b000001; cfg = '0;
    step(D + 2);
    check(ls[0] && !hs[0], "R2 low side", 32'({hs[0], ls[0]}), 32'h1);
    cfg[0] = 1'b1;
    step(1);
    check(!hs[0] && !ls[0], "R4 break edge", 32'({hs[0], ls[0]}), 32'h0);
    for (int j = 1; j < D; j++) begin
      step(1);
      check(!hs[0] && !ls[0], "R4 gap", 32'({hs[0], ls[0]}), 32'h0);
    end
    step(1);
    check(hs[0] && !ls[0], "R4 make high", 32'({hs[0], ls[0]}), 32'h2);

    // R4 high -> low
    cfg[0] = 1'b0;
    step(1);
    check(!hs[0] && !ls[0], "R4 break edge", 32'({hs[0], ls[0]}), 32'h0);
    step(D - 1);
    check(!hs[0] && !ls[0], "R4 gap end", 32'({hs[0], ls[0]}), 32'h0);
    step(1);
    check(ls[0] && !hs[0], "R4 make low", 32'({hs[0], ls[0]}), 32'h1);

    // R5 low -> high-Z -> high still waits
    en[0] = 1'b0;
    step(1);
    check(!hs[0] && !ls[0], "R5 hiz", 32'({hs[0], ls[0]}), 32'h0);
    en[0] = 1'b1; cfg[0] = 1'b1;
    step(D - 1);
    check(!hs[0] && !ls[0], "R5 wait", 32'({hs[0], ls[0]}), 32'h0);
    step(1);
    check(hs[0] && !ls[0], "R5 opposite on", 32'({hs[0], ls[0]}), 32'h2);
    // R5 same side returns at once
    en[0] = 1'b0;
    step(1);
    en[0] = 1'b1;
    step(1);
    check(hs[0] && !ls[0], "R5 same side", 32'({hs[0], ls[0]}), 32'h2);

    // R6 lockout keeps programmed state and resumes
    en = 6'b110011; cfg = 6'b010001;
    step(D + 2);
    steady("R2 mixed");
    lock = 1'b1;
    step(1);
    check(hs == '0 && ls == '0, "R6 off", 32'({hs, ls}), 32'h0);
    check(ee == en && ce == cfg, "R6 echo kept", 32'({ee, ce}), 32'({en, cfg}));
    step(4);
    lock = 1'b0;
    step(1);
    steady("R6 resume");

    // R7 fault latch
    flt = 6'b000011;
    #1;
    check(ee[1:0] == 2'b00 && ce[1:0] == 2'b00, "R7 echo", 32'({ee, ce}), 32'h0);
    step(1);
    check(hs[1:0] == 2'b00 && ls[1:0] == 2'b00, "R7 off", 32'({hs, ls}), 32'h0);
    flt = '0;

    // R1 R2 R7 R6 R9 sweep of patterns
    for (int k = 0; k < 64; k++) begin
      en   = N'((k * 37 + 5) % 64);
      cfg  = N'((k * 11 + 9) % 64);
      flt  = (k % 5 == 2) ? N'((k * 13) % 64) : '0;
      lock = (k % 7 == 3);
      step(D + 2);
      steady(lock ? "R6 sweep" : (flt != 0 ? "R7 sweep" : "R1 R2 sweep"));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule